// File: doc/BRIEF.md
# Indexed Drive-Controller Configuration Register File

This block holds the configuration space of a two-channel disk-interface controller. The host reaches it through two ports on a byte-wide I/O bus. A byte written to the index port selects one internal register, and reads and writes at the data port then go to that register. The registers cover a configuration/revision byte, a control byte, a command-timing byte, address-setup and read/write timing bytes for three drive slots, a prefetch burst-size byte and a scratch byte. Software uses the scratch byte to check that the controller is present.

Some read-only bits sit inside otherwise writable bytes. These are the fixed revision code, a strap pin that reports which alternate base address the port pair decodes at, and one live interrupt-status bit per channel. The stored contents drive plain outputs: the prefetch-disable flag for each drive, the secondary-channel enable, and every timing and burst byte. The strobe generator beside this block uses those outputs.

The host side is a request/response stream. A request is taken in every cycle that `req_valid` is high, because the block never applies back-pressure. No ready signal exists. Each read request produces exactly one response, with `rsp_valid` high in the following cycle. The consumer must accept that response in that cycle.

Top module: `cfgidx_regfile`

## Requirements
- R1: Port offset 0 is the index port. A write there stores `req_wdata` as the current index, and a read there returns the current index. Accesses at offsets other than 0 and 4 change nothing, and reads at those offsets return 0x00.
- R2: Every request with `req_valid=1, req_write=0` gives `rsp_valid=1` with its data in the next cycle. `rsp_valid` is 0 in every other cycle.
- R3: Index 0x50 (configuration) reads bits [1:0] as the parameter REVISION, bit 5 as the `alt_base` pin and bit 2 as the live `irq_pri` pin, and writes do not change any of these bits. Bit 1:0 = 0 marks an unsupported part. Bits 7, 6, 4 and 3 are stored read/write.
- R4: Index 0x57 reads bit 4 as the live `irq_sec` pin, and writes do not change it.
- R5: Index 0x51 (control) is fully read/write. Bit 6 and bit 7 drive `prefetch_off[0]` and `prefetch_off[1]`, and bit 3 drives `sec_chan_en`. Each output changes in the cycle after the write.
- R6: Bits 2 and 3 of index 0x57 drive `prefetch_off[2]` and `prefetch_off[3]`. These are the drives that share the secondary channel.
- R7: Index 0x5B is a plain scratch byte. Any value written there reads back unchanged.
- R8: Index 0x52 drives `cmd_timing`. Each slot k (0..2) has an address-setup byte at 0x53+2k and a read/write timing byte at 0x54+2k, which appear on `addr_setup[8k+:8]` and `rw_timing[8k+:8]`. All of these read back what was written, apart from the read-only bit of R4.
- R9: Index 0x59 drives `burst_cfg`. It reads back what was written, and its reset value 0x40 selects 512-byte bursts.
- R10: Indices outside 0x50..0x5B, and index 0x5A, read as 0x00, and writes to them change no readable register and no output.
- R11: After reset the index is 0x00. The stored configuration bits are 0. Control is 0xC0, index 0x57 stores 0x0C, the burst byte is 0x40, and every other byte is 0x00. This is the slowest-timing, all-prefetch-disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access request, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 3 | Port offset: 0 is index, 4 is data |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_data | output | 8 | Read response data |
| irq_pri | input | 1 | Primary channel interrupt status |
| irq_sec | input | 1 | Secondary channel interrupt status |
| alt_base | input | 1 | Strap: alternate base address selected |
| prefetch_off | output | 4 | Prefetch disable for each drive 0..3 |
| sec_chan_en | output | 1 | Secondary channel enable |
| cmd_timing | output | 8 | Command-block timing byte |
| addr_setup | output | 24 | Address-setup byte for each slot |
| rw_timing | output | 24 | Read/write timing byte for each slot |
| burst_cfg | output | 8 | Prefetch burst-size byte |

## Verification
The hardest case to reach is a data-port access that lands on the wrong byte because the index was changed earlier, possibly by an access several operations back. This matters most at index 0x57, where stored prefetch bits, a writable setup field and a live interrupt bit share one byte. The stimulus therefore mixes index writes and data accesses at random over a window of indices from 0x4C to 0x5F, which includes both unimplemented neighbours and the gap at 0x5A. The interrupt and strap pins are toggled between operations, so that any read-only bit that had latched a written value would show up.

// File: rtl/cfgidx_pkg.sv
package cfgidx_pkg;
  localparam int          NUM_SLOTS   = 3;
  localparam int          SLOT_W      = $clog2(NUM_SLOTS);
  localparam int          SLOT_SHARED = NUM_SLOTS - 1;

  localparam logic [2:0]  PORT_INDEX  = 3'd0;
  localparam logic [2:0]  PORT_DATA   = 3'd4;

  localparam logic [7:0]  IX_CONFIG   = 8'h50;
  localparam logic [7:0]  IX_CONTROL  = 8'h51;
  localparam logic [7:0]  IX_CMDTIME  = 8'h52;
  localparam logic [7:0]  IX_SLOT0    = 8'h53;
  localparam logic [7:0]  IX_BURST    = IX_SLOT0 + 8'(2 * NUM_SLOTS);
  localparam logic [7:0]  IX_SCRATCH  = IX_BURST + 8'd2;

  // writable masks and reset values of stored bytes
  localparam logic [7:0]  CONFIG_WMASK = 8'hD8;
  localparam logic [7:0]  SHARED_WMASK = 8'hEF;
  localparam logic [7:0]  SHARED_RST   = 8'h0C;
  localparam logic [7:0]  CONTROL_RST  = 8'hC0;
  localparam logic [7:0]  BURST_RST    = 8'h40;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CONFIG, SEL_CONTROL, SEL_CMDTIME,
    SEL_ASETUP, SEL_RWTIME, SEL_BURST, SEL_SCRATCH
  } sel_e;

  typedef struct packed {
    sel_e              kind;
    logic [SLOT_W-1:0] slot;
  } dec_t;
endpackage

// File: rtl/cfgidx_decode.sv
module cfgidx_decode
  import cfgidx_pkg::*;
(
  input  logic [7:0] idx,
  output dec_t       dec
);
  localparam logic [7:0] SLOT_LAST = IX_SLOT0 + 8'(2 * NUM_SLOTS - 1);

  logic [7:0] off;

  always_comb begin
    off      = idx - IX_SLOT0;
    dec.kind = SEL_NONE;
    dec.slot = '0;
    if (idx == IX_CONFIG)        dec.kind = SEL_CONFIG;
    else if (idx == IX_CONTROL)  dec.kind = SEL_CONTROL;
    else if (idx == IX_CMDTIME)  dec.kind = SEL_CMDTIME;
    else if (idx == IX_BURST)    dec.kind = SEL_BURST;
    else if (idx == IX_SCRATCH)  dec.kind = SEL_SCRATCH;
    else if (idx >= IX_SLOT0 && idx <= SLOT_LAST) begin
      dec.kind = off[0] ? SEL_RWTIME : SEL_ASETUP;
      dec.slot = off[SLOT_W:1];
    end
  end
endmodule

// File: rtl/cfgidx_store.sv
module cfgidx_store
  import cfgidx_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  dec_t                         dec,
  input  logic [7:0]                   wdata,
  output logic [7:0]                   config_q,
  output logic [7:0]                   control_q,
  output logic [7:0]                   cmdtime_q,
  output logic [NUM_SLOTS-1:0][7:0]    asetup_q,
  output logic [NUM_SLOTS-1:0][7:0]    rwtime_q,
  output logic [7:0]                   burst_q,
  output logic [7:0]                   scratch_q
);
  function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] nw,
                                       input logic [7:0] mask);
    return (old & ~mask) | (nw & mask);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      config_q  <= 8'h00;
      control_q <= CONTROL_RST;
      cmdtime_q <= 8'h00;
      burst_q   <= BURST_RST;
      scratch_q <= 8'h00;
    end else if (we) begin
      case (dec.kind)
        SEL_CONFIG:  config_q  <= merge(config_q, wdata, CONFIG_WMASK);
        SEL_CONTROL: control_q <= wdata;
        SEL_CMDTIME: cmdtime_q <= wdata;
        SEL_BURST:   burst_q   <= wdata;
        SEL_SCRATCH: scratch_q <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [7:0] AMASK = (k == SLOT_SHARED) ? SHARED_WMASK : 8'hFF;
    localparam logic [7:0] ARST  = (k == SLOT_SHARED) ? SHARED_RST   : 8'h00;
    logic hit;
    assign hit = we && (dec.slot == SLOT_W'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        asetup_q[k] <= ARST;
        rwtime_q[k] <= 8'h00;
      end else if (hit && dec.kind == SEL_ASETUP) begin
        asetup_q[k] <= merge(asetup_q[k], wdata, AMASK);
      end else if (hit && dec.kind == SEL_RWTIME) begin
        rwtime_q[k] <= wdata;
      end
    end
  end
endmodule

// File: rtl/cfgidx_rdmux.sv
module cfgidx_rdmux
  import cfgidx_pkg::*;
#(
  parameter logic [1:0] REVISION = 2'd2
)(
  input  dec_t                      dec,
  input  logic [7:0]                config_q,
  input  logic [7:0]                control_q,
  input  logic [7:0]                cmdtime_q,
  input  logic [NUM_SLOTS-1:0][7:0] asetup_q,
  input  logic [NUM_SLOTS-1:0][7:0] rwtime_q,
  input  logic [7:0]                burst_q,
  input  logic [7:0]                scratch_q,
  input  logic                      irq_pri,
  input  logic                      irq_sec,
  input  logic                      alt_base,
  output logic [7:0]                rd_byte
);
  logic [7:0] live_cfg;
  logic [7:0] live_shared;

  assign live_cfg    = {2'b00, alt_base, 2'b00, irq_pri, REVISION};
  assign live_shared = {3'b000, irq_sec, 4'b0000};

  always_comb begin
    rd_byte = 8'h00;
    case (dec.kind)
      SEL_CONFIG:  rd_byte = (config_q & CONFIG_WMASK) | live_cfg;
      SEL_CONTROL: rd_byte = control_q;
      SEL_CMDTIME: rd_byte = cmdtime_q;
      SEL_ASETUP:  rd_byte = asetup_q[dec.slot] |
                             ((int'(dec.slot) == SLOT_SHARED) ? live_shared : 8'h00);
      SEL_RWTIME:  rd_byte = rwtime_q[dec.slot];
      SEL_BURST:   rd_byte = burst_q;
      SEL_SCRATCH: rd_byte = scratch_q;
      default:     rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfgidx_regfile.sv
module cfgidx_regfile
  import cfgidx_pkg::*;
#(
  parameter logic [1:0] REVISION = 2'd2
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [2:0]             req_port,
  input  logic [7:0]             req_wdata,
  output logic                   rsp_valid,
  output logic [7:0]             rsp_data,
  input  logic                   irq_pri,
  input  logic                   irq_sec,
  input  logic                   alt_base,
  output logic [3:0]             prefetch_off,
  output logic                   sec_chan_en,
  output logic [7:0]             cmd_timing,
  output logic [NUM_SLOTS*8-1:0] addr_setup,
  output logic [NUM_SLOTS*8-1:0] rw_timing,
  output logic [7:0]             burst_cfg
);
  logic [7:0]                index_q;
  dec_t                      dec;
  logic                      data_we;
  logic [7:0]                rd_byte;
  logic [7:0]                config_q, control_q, cmdtime_q, burst_q, scratch_q;
  logic [NUM_SLOTS-1:0][7:0] asetup_q, rwtime_q;

  assign data_we = req_valid && req_write && (req_port == PORT_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= 8'h00;
    else if (req_valid && req_write && req_port == PORT_INDEX) index_q <= req_wdata;
  end

  cfgidx_decode u_dec (.idx(index_q), .dec(dec));

  cfgidx_store u_store (
    .clk(clk), .rst_n(rst_n), .we(data_we), .dec(dec), .wdata(req_wdata),
    .config_q(config_q), .control_q(control_q), .cmdtime_q(cmdtime_q),
    .asetup_q(asetup_q), .rwtime_q(rwtime_q), .burst_q(burst_q), .scratch_q(scratch_q)
  );

  cfgidx_rdmux #(.REVISION(REVISION)) u_mux (
    .dec(dec), .config_q(config_q), .control_q(control_q), .cmdtime_q(cmdtime_q),
    .asetup_q(asetup_q), .rwtime_q(rwtime_q), .burst_q(burst_q), .scratch_q(scratch_q),
    .irq_pri(irq_pri), .irq_sec(irq_sec), .alt_base(alt_base), .rd_byte(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        case (req_port)
          PORT_INDEX: rsp_data <= index_q;
          PORT_DATA:  rsp_data <= rd_byte;
          default:    rsp_data <= 8'h00;
        endcase
      end
    end
  end

  assign prefetch_off = {asetup_q[SLOT_SHARED][3], asetup_q[SLOT_SHARED][2],
                         control_q[7], control_q[6]};
  assign sec_chan_en  = control_q[3];
  assign cmd_timing   = cmdtime_q;
  assign addr_setup   = asetup_q;
  assign rw_timing    = rwtime_q;
  assign burst_cfg    = burst_q;
endmodule

// File: rtl/cfgidx_checker.sv
module cfgidx_checker
  import cfgidx_pkg::*;
#(
  parameter logic [1:0] REVISION = 2'd2
)(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic [2:0] req_port,
  input logic [7:0] req_wdata,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic [3:0] prefetch_off,
  input logic       sec_chan_en,
  input logic [7:0] idx
);
  logic rd_req, data_rd, data_wr, unimpl;
  assign rd_req  = req_valid && !req_write;
  assign data_rd = rd_req && req_port == PORT_DATA;
  assign data_wr = req_valid && req_write && req_port == PORT_DATA;
  assign unimpl  = idx < IX_CONFIG || idx > IX_SCRATCH || idx == 8'h5A;

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid); // R2
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid); // R2
  AST_INDEX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && req_port == PORT_INDEX) |=> rsp_data == $past(idx)); // R1
  AST_REVISION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && idx == IX_CONFIG) |=> rsp_data[1:0] == REVISION); // R3
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && unimpl) |=> rsp_data == 8'h00); // R10
  AST_CONTROL_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && idx == IX_CONTROL) |=>
      (prefetch_off[1:0] == {$past(req_wdata[7]), $past(req_wdata[6])}) &&
      (sec_chan_en == $past(req_wdata[3]))); // R5
  AST_PREFETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(prefetch_off)); // R6
endmodule

bind cfgidx_regfile cfgidx_checker #(.REVISION(REVISION)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_port(req_port), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .prefetch_off(prefetch_off), .sec_chan_en(sec_chan_en),
  .idx(index_q)
);

// File: tb/cfgidx_regfile_test.sv
module cfgidx_regfile_test;
  localparam logic [1:0] REV = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_port = 3'd0;
  logic [7:0]  req_wdata = 8'h00;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        irq_pri = 1'b0, irq_sec = 1'b0, alt_base = 1'b0;
  logic [3:0]  prefetch_off;
  logic        sec_chan_en;
  logic [7:0]  cmd_timing, burst_cfg;
  logic [23:0] addr_setup, rw_timing;

  int tests = 0, fails = 0;
  logic [7:0] mdl [256];
  logic [7:0] cur_idx;
  logic [7:0] got;
  logic       got_v;

  always #10 clk = ~clk;

  cfgidx_regfile #(.REVISION(REV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_port(req_port), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq_pri(irq_pri), .irq_sec(irq_sec), .alt_base(alt_base),
    .prefetch_off(prefetch_off), .sec_chan_en(sec_chan_en), .cmd_timing(cmd_timing),
    .addr_setup(addr_setup), .rw_timing(rw_timing), .burst_cfg(burst_cfg)
  );

  // writable bits per index, from the requirements
  function automatic logic [7:0] wmask(input logic [7:0] i);
    if (i == 8'h50) return 8'hD8;                    // R3
    if (i == 8'h57) return 8'hEF;                    // R4
    if (i >= 8'h51 && i <= 8'h59) return 8'hFF;      // R5 R8 R9
    if (i == 8'h5B) return 8'hFF;                    // R7
    return 8'h00;                                    // R10
  endfunction

  function automatic logic [7:0] expect_rd(input logic [7:0] i);
    logic [7:0] v;
    v = mdl[i] & wmask(i);
    if (i == 8'h50) v = v | {2'b00, alt_base, 2'b00, irq_pri, REV};
    if (i == 8'h57) v = v | {3'b000, irq_sec, 4'b0000};
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] p, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_port = p; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (p == 3'd0) cur_idx = d;
    else if (p == 3'd4) mdl[cur_idx] = (mdl[cur_idx] & ~wmask(cur_idx)) | (d & wmask(cur_idx));
  endtask

  task automatic rd(input logic [2:0] p);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_port = p;
    @(negedge clk);
    req_valid = 1'b0;
    got_v = rsp_valid; got = rsp_data;
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " prefetch_off"}, 32'(prefetch_off),
          32'({mdl[8'h57][3], mdl[8'h57][2], mdl[8'h51][7], mdl[8'h51][6]}));
    check({tag, " sec_chan_en"}, 32'(sec_chan_en), 32'(mdl[8'h51][3]));
    check({tag, " cmd_timing"}, 32'(cmd_timing), 32'(mdl[8'h52]));
    check({tag, " addr_setup"}, 32'(addr_setup),
          32'({mdl[8'h57] & 8'hEF, mdl[8'h55], mdl[8'h53]}));
    check({tag, " rw_timing"}, 32'(rw_timing), 32'({mdl[8'h58], mdl[8'h56], mdl[8'h54]}));
    check({tag, " burst_cfg"}, 32'(burst_cfg), 32'(mdl[8'h59]));
  endtask

  task automatic rd_data_check(input string tag, input logic [7:0] i);
    rd(3'd4);
    check({tag, " rsp_valid"}, 32'(got_v), 32'd1);
    check(tag, 32'(got), 32'(expect_rd(i)));
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mdl[8'h51] = 8'hC0; mdl[8'h57] = 8'h0C; mdl[8'h59] = 8'h40; // R11
    cur_idx = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 rsp_valid idle", 32'(rsp_valid), 32'd0);
    check_outputs("R11 reset");
    rd(3'd0);
    check("R11 index reset", 32'(got), 32'h00);
    for (int i = 8'h50; i <= 8'h5B; i++) begin
      wr(3'd0, 8'(i));
      rd_data_check("R11 reset read", 8'(i));
    end

    // R7 scratch presence check
    wr(3'd0, 8'h5B); wr(3'd4, 8'hBD); rd_data_check("R7 scratch BD", 8'h5B);
    check("R7 scratch literal", 32'(got), 32'hBD);
    wr(3'd4, 8'h00); rd_data_check("R7 scratch 00", 8'h5B);

    // R3 revision and live bits
    wr(3'd0, 8'h50); wr(3'd4, 8'hFF);
    irq_pri = 1'b1; alt_base = 1'b1;
    rd_data_check("R3 config after FF", 8'h50);
    check("R3 revision bits", 32'(got[1:0]), 32'(REV));
    irq_pri = 1'b0; alt_base = 1'b0; wr(3'd4, 8'h00);
    rd_data_check("R3 config after 00", 8'h50);

    // R4 live irq_sec and R6 shared prefetch bits
    wr(3'd0, 8'h57); wr(3'd4, 8'h10);
    check_outputs("R6 after 10");
    irq_sec = 1'b0; rd_data_check("R4 irq_sec low", 8'h57);
    check("R4 irq bit not stored", 32'(got[4]), 32'd0);
    irq_sec = 1'b1; rd_data_check("R4 irq_sec high", 8'h57);
    wr(3'd4, 8'h04); check_outputs("R6 drive2 only");

    // R5 control
    wr(3'd0, 8'h51); wr(3'd4, 8'h48); check_outputs("R5 control 48");
    wr(3'd4, 8'h80); check_outputs("R5 control 80");

    // R10 unimplemented and R1 stray ports
    wr(3'd0, 8'h5A); wr(3'd4, 8'hA5); rd_data_check("R10 gap 5A", 8'h5A);
    check("R10 gap literal", 32'(got), 32'h00);
    check_outputs("R10 after gap write");
    wr(3'd0, 8'h20); wr(3'd4, 8'h77); rd_data_check("R10 low index", 8'h20);
    wr(3'd0, 8'h5B); wr(3'd2, 8'h50); rd(3'd0);
    check("R1 stray port keeps index", 32'(got), 32'h5B);
    rd(3'd6); check("R1 stray port reads 0", 32'(got), 32'h00);
    check("R2 stray port responds", 32'(got_v), 32'd1);

    // R8 R9 and constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 3);
      irq_pri = 1'($urandom); irq_sec = 1'($urandom); alt_base = 1'($urandom);
      if (op == 0) wr(3'd0, 8'($urandom_range(8'h4C, 8'h5F)));
      else if (op == 1) begin
        wr(3'd4, 8'($urandom));
        check_outputs("R8 R9 random write");
      end else if (op == 2) rd_data_check("R8 random read", cur_idx);
      else begin
        rd(3'd0);
        check("R1 random index read", 32'(got), 32'(cur_idx));
      end
    end

    // R2 no response after a write
    wr(3'd4, 8'h11);
    check("R2 no rsp after write", 32'(rsp_valid), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule